// File: doc/BRIEF.md
# Binary64 Rounding Stage

This stage sits after an iterative mantissa divider and turns its pre-rounding result into a packed 64-bit binary64 word. It receives the sign, a 12-bit biased exponent and a 56-bit mantissa word. The mantissa word has a spare zero at its top that catches a rounding carry, then the leading one, 52 fraction bits, a guard bit and a sticky bit. A 2-bit select picks one of four rounding rules. The stage works out whether the 53-bit significand must be bumped by one unit in the last place. If that bump carries into the spare slot, the stage renormalizes by one place and raises the exponent.

The result is held in a register that loads only on cycles where the enable is high. The packed output keeps the sign, the low 11 exponent bits and the 52 fraction bits. The full 12-bit exponent after rounding is also given out, so that a later exception stage can tell overflow. An inexact flag reports any discarded tail. Overflow, underflow, invalid-operation decisions and special-value substitution are left to that later stage.

Top module: `fp64_round_stage`

## Requirements
- R1: While reset is high, at the next clock edge the packed result, the exponent output and the inexact flag all become zero.
- R2: Mode 2'b00 (nearest, ties to even) adds one to the significand only when the guard bit (mantissa word bit 1) is 1 and either the sticky bit (bit 0) or the fraction LSB (bit 2) is 1.
- R3: Mode 2'b01 (toward zero) never adds one; the fraction and the exponent pass through unchanged.
- R4: Mode 2'b10 (toward plus infinity) adds one only when the sign is 0 and the guard or sticky bit is 1.
- R5: Mode 2'b11 (toward minus infinity) adds one only when the sign is 1 and the guard or sticky bit is 1.
- R6: When the increment carries into mantissa word bit 55, the significand is shifted right by one place (the fraction becomes zero) and the exponent output is the input exponent plus one.
- R7: The inexact flag is the OR of the guard and sticky bits, in every mode.
- R8: Result bit 63 is the sign, bits 62:52 are the low 11 bits of the rounded exponent, and bits 51:0 are the rounded fraction; the exponent output carries all 12 bits, including bit 11.
- R9: On a clock edge where enable is low, all outputs keep their previous values.
- R10: Inputs sampled at an enabled clock edge appear on the outputs right after that edge, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Load enable for the result register |
| rnd_mode_i | input | 2 | Rounding rule select |
| sign_i | input | 1 | Sign of the quotient |
| exp_i | input | 12 | Biased exponent before rounding |
| mant_i | input | 56 | Carry slot, leading one, fraction, guard, sticky |
| res_o | output | 64 | Packed rounded binary64 word |
| exp_o | output | 12 | Exponent after rounding |
| inexact_o | output | 1 | Discarded tail was non-zero |

## Verification
The bench goes after the ties of nearest-even, with an even LSB that must stay and an odd LSB that must round up. A design that rounds ties away from zero fails the first, and one that ignores the LSB fails the second. It crosses both directed modes with both signs, because swapping the sign test between plus and minus infinity gives a result off by one in the last place. All-ones fractions drive the carry into the spare slot. Here a missing renormalization leaves a wrong fraction and an unchanged exponent, and a dropped exponent bit 11 loses the overflow hint. Idle enable cycles and a mid-run reset show whether the register loads when it must not.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
    localparam int FRAC_W = 52;
    localparam int EXP_W  = 11;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_TO_ZERO   = 2'b01,
        RND_TO_POS    = 2'b10,
        RND_TO_NEG    = 2'b11
    } rnd_mode_e;
endpackage

// File: rtl/fpr_decide.sv
module fpr_decide (
    input  logic [1:0] mode_i,
    input  logic       sign_i,
    input  logic       lsb_i,
    input  logic       guard_i,
    input  logic       sticky_i,
    output logic       bump_o,
    output logic       tail_o
);
    import fpr_pkg::*;

    rnd_mode_e mode;

    always_comb begin
        mode   = rnd_mode_e'(mode_i);
        tail_o = guard_i | sticky_i;
        unique case (mode)
            RND_NEAR_EVEN: bump_o = guard_i & (sticky_i | lsb_i);
            RND_TO_ZERO:   bump_o = 1'b0;
            RND_TO_POS:    bump_o = ~sign_i & tail_o;
            RND_TO_NEG:    bump_o = sign_i & tail_o;
            default:       bump_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpr_incr.sv
module fpr_incr #(
    parameter int FRAC_W = 52,
    parameter int EXP_W  = 11
) (
    input  logic [FRAC_W+1:0] body_i,
    input  logic [EXP_W:0]    exp_i,
    input  logic              bump_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic [EXP_W:0]    exp_o
);
    localparam int BODY_W = FRAC_W + 2;

    logic [BODY_W-1:0] sum;
    logic              carry;

    always_comb begin
        sum   = body_i + {{(BODY_W-1){1'b0}}, bump_i};
        carry = sum[BODY_W-1];
        if (carry) begin
            frac_o = sum[FRAC_W:1];
            exp_o  = exp_i + {{EXP_W{1'b0}}, 1'b1};
        end else begin
            frac_o = sum[FRAC_W-1:0];
            exp_o  = exp_i;
        end
    end
endmodule

// File: rtl/fp64_round_stage.sv
module fp64_round_stage #(
    parameter int FRAC_W = fpr_pkg::FRAC_W,
    parameter int EXP_W  = fpr_pkg::EXP_W
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic [1:0]              rnd_mode_i,
    input  logic                    sign_i,
    input  logic [EXP_W:0]          exp_i,
    input  logic [FRAC_W+3:0]       mant_i,
    output logic [FRAC_W+EXP_W:0]   res_o,
    output logic [EXP_W:0]          exp_o,
    output logic                    inexact_o
);
    localparam int MANT_W = FRAC_W + 4;
    localparam int WORD_W = FRAC_W + EXP_W + 1;
    localparam int SIGN_B = WORD_W - 1;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [EXP_W:0]    expo;
        logic              inexact;
    } stage_t;

    stage_t stage_d, stage_q;

    logic              bump, tail;
    logic [FRAC_W-1:0] frac_r;
    logic [EXP_W:0]    exp_r;

    fpr_decide i_decide (
        .mode_i   (rnd_mode_i),
        .sign_i   (sign_i),
        .lsb_i    (mant_i[2]),
        .guard_i  (mant_i[1]),
        .sticky_i (mant_i[0]),
        .bump_o   (bump),
        .tail_o   (tail)
    );

    fpr_incr #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) i_incr (
        .body_i (mant_i[MANT_W-1:2]),
        .exp_i  (exp_i),
        .bump_i (bump),
        .frac_o (frac_r),
        .exp_o  (exp_r)
    );

    always_comb begin
        stage_d = stage_q;
        if (en_i) begin
            stage_d.word    = {sign_i, exp_r[EXP_W-1:0], frac_r};
            stage_d.expo    = exp_r;
            stage_d.inexact = tail;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) stage_q <= '0;
        else       stage_q <= stage_d;
    end

    assign res_o     = stage_q.word;
    assign exp_o     = stage_q.expo;
    assign inexact_o = stage_q.inexact;

    p_reset_r1: assert property (@(posedge clk_i)
        rst_i |=> (res_o == '0) && (exp_o == '0) && !inexact_o);

    p_exact_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !mant_i[1] && !mant_i[0])
        |=> (exp_o == $past(exp_i)) && (res_o[FRAC_W-1:0] == $past(mant_i[FRAC_W+1:2])));

    p_trunc_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && rnd_mode_i == 2'b01 && !mant_i[MANT_W-1])
        |=> (exp_o == $past(exp_i)) && (res_o[FRAC_W-1:0] == $past(mant_i[FRAC_W+1:2])));

    p_carry_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (exp_o == $past(exp_i))
              || ((exp_o == $past(exp_i) + 1'b1) && (res_o[FRAC_W-1:0] == '0)));

    p_inexact_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> inexact_o == $past(mant_i[1] | mant_i[0]));

    p_pack_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (res_o[SIGN_B] == $past(sign_i))
              && (res_o[FRAC_W +: EXP_W] == exp_o[EXP_W-1:0]));

    p_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(res_o) && $stable(exp_o) && $stable(inexact_o));
endmodule

// File: tb/test_fp64_round_stage.sv
module test_fp64_round_stage;
    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [1:0]  mode;
    logic        sgn;
    logic [11:0] ex;
    logic [55:0] mant;
    logic [63:0] res;
    logic [11:0] exo;
    logic        inx;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fp64_round_stage i_fp64_round_stage (
        .clk_i(clk), .rst_i(rst), .en_i(en), .rnd_mode_i(mode), .sign_i(sgn),
        .exp_i(ex), .mant_i(mant), .res_o(res), .exp_o(exo), .inexact_o(inx)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic        sg;
        logic [11:0] ei;
        logic [51:0] fi;
        logic        g;
        logic        s;
        logic [51:0] fo;
        logic [11:0] eo;
        logic        xo;
        logic [3:0]  req;
    } vec_t;

    localparam logic [51:0] ONES = {52{1'b1}};

    localparam vec_t VECS [17] = '{
        '{2'd0, 1'b0, 12'h400, 52'h0,  1'b1, 1'b0, 52'h0,  12'h400, 1'b1, 4'd2}, // R2 tie, even stays
        '{2'd0, 1'b0, 12'h400, 52'h1,  1'b1, 1'b0, 52'h2,  12'h400, 1'b1, 4'd2}, // R2 tie, odd rounds up
        '{2'd0, 1'b1, 12'h400, 52'h0,  1'b1, 1'b1, 52'h1,  12'h400, 1'b1, 4'd2}, // R2 above half
        '{2'd0, 1'b0, 12'h400, 52'h3,  1'b0, 1'b1, 52'h3,  12'h400, 1'b1, 4'd2}, // R2 below half
        '{2'd1, 1'b0, 12'h400, 52'h5,  1'b1, 1'b1, 52'h5,  12'h400, 1'b1, 4'd3}, // R3
        '{2'd1, 1'b1, 12'h400, 52'h5,  1'b1, 1'b0, 52'h5,  12'h400, 1'b1, 4'd3}, // R3
        '{2'd2, 1'b0, 12'h400, 52'h10, 1'b0, 1'b1, 52'h11, 12'h400, 1'b1, 4'd4}, // R4 positive
        '{2'd2, 1'b1, 12'h400, 52'h10, 1'b1, 1'b1, 52'h10, 12'h400, 1'b1, 4'd4}, // R4 negative
        '{2'd2, 1'b0, 12'h400, 52'h5,  1'b0, 1'b0, 52'h5,  12'h400, 1'b0, 4'd4}, // R4 exact
        '{2'd3, 1'b1, 12'h400, 52'h10, 1'b0, 1'b1, 52'h11, 12'h400, 1'b1, 4'd5}, // R5 negative
        '{2'd3, 1'b0, 12'h400, 52'h10, 1'b1, 1'b0, 52'h10, 12'h400, 1'b1, 4'd5}, // R5 positive
        '{2'd0, 1'b0, 12'h3fe, ONES,   1'b1, 1'b1, 52'h0,  12'h3ff, 1'b1, 4'd6}, // R6 nearest carry
        '{2'd2, 1'b0, 12'h7fe, ONES,   1'b0, 1'b1, 52'h0,  12'h7ff, 1'b1, 4'd6}, // R6 up carry
        '{2'd0, 1'b0, 12'h7ff, ONES,   1'b1, 1'b1, 52'h0,  12'h800, 1'b1, 4'd6}, // R6 into bit 11
        '{2'd1, 1'b1, 12'h3ff, 52'h123456789abcd, 1'b0, 1'b0,
                               52'h123456789abcd, 12'h3ff, 1'b0, 4'd7},           // R7 exact
        '{2'd1, 1'b0, 12'h800, 52'h1,  1'b0, 1'b0, 52'h1,  12'h800, 1'b0, 4'd8}, // R8 bit 11 kept apart
        '{2'd3, 1'b1, 12'h400, ONES,   1'b1, 1'b0, 52'h0,  12'h401, 1'b1, 4'd5}  // R5 with carry
    };

    task automatic check(input string req, input logic [76:0] got, input logic [76:0] want);
        n_run++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, want);
        end
    endtask

    task automatic drive(input logic e, input logic [1:0] m, input logic s,
                         input logic [11:0] x, input logic [51:0] f,
                         input logic g, input logic st);
        en = e; mode = m; sgn = s; ex = x; mant = {1'b0, 1'b1, f, g, st};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        finish_run();
    end

    initial begin
        logic [76:0] last;
        rst = 1'b1;
        drive(1'b0, 2'd0, 1'b0, 12'h0, 52'h0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {res, exo, inx}, 77'h0);
        rst = 1'b0;

        foreach (VECS[i]) begin
            drive(1'b1, VECS[i].md, VECS[i].sg, VECS[i].ei, VECS[i].fi, VECS[i].g, VECS[i].s);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d/R8 vector %0d", VECS[i].req, i), {res, exo, inx},
                  {VECS[i].sg, VECS[i].eo[10:0], VECS[i].fo, VECS[i].eo, VECS[i].xo});
        end

        // R10: value present before the edge is still the old one
        last = {res, exo, inx};
        drive(1'b1, 2'd1, 1'b1, 12'h155, 52'habc, 1'b1, 1'b0);
        #1;
        check("R10 before edge", {res, exo, inx}, last);
        @(posedge clk);
        @(negedge clk);
        check("R10 after edge", {res, exo, inx}, {1'b1, 11'h155, 52'habc, 12'h155, 1'b1});

        // R9: enable low, new inputs ignored across several edges
        last = {res, exo, inx};
        drive(1'b0, 2'd0, 1'b0, 12'h3ff, ONES, 1'b1, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 hold", {res, exo, inx}, last);

        // R9 then enable again picks up the waiting inputs (R6 path)
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9/R6 resume", {res, exo, inx}, {1'b0, 11'h400, 52'h0, 12'h400, 1'b1});

        // R1: reset in mid-stream wins over enable
        rst = 1'b1;
        drive(1'b1, 2'd2, 1'b0, 12'h222, 52'h7, 1'b1, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check("R1 mid reset", {res, exo, inx}, 77'h0);
        rst = 1'b0;
        en  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9 after reset", {res, exo, inx}, 77'h0);

        finish_run();
    end
endmodule